// File: doc/BRIEF.md
# Printer Carriage and Page Counter

This block keeps track of how many lines have been used on the current printer page. Around every printed line it applies the carriage-control requests that arrived while the line was being assembled. Spacing requests come in as a five-bit field. Each field is OR-ed into a request register that lives until the next accepted print command. On the print strobe, the block computes the total paper advance. That advance is made of the explicit spaces before the line, one default line feed, any space after the line, and an optional skip to the top of the next page. It reports the advance as a line-feed count. When the page fills up, it wraps the line counter by subtracting the page length and pulses a page-overflow flag.

The block also qualifies print commands from a two-bit device code and reports binary mode. It gives the start-up delay to use, which depends on whether the mechanism is already turning. The page length can be programmed, and a write port checks each new value against the legal range. Producing the characters and moving the paper are left to other logic.

Top module: `carriage_page_ctrl`

## Requirements
- R1: A page-length write with a value from 20 to 100 inclusive is accepted, and on the following clock edge the line count reads 0.
- R2: A page-length write outside 20..100 is ignored. The line count and the page length stay unchanged.
- R3: Every print advances one default line unless the suppress request (req_bits[2]) is set; suppress overprints on the current line.
- R4: The single-space-before request (req_bits[0]) adds one line and the double-space-before request (req_bits[1]) adds two lines to the advance.
- R5: The space-after request (req_bits[3]) adds one more line to the advance.
- R6: The skip-to-top request (req_bits[4]) raises the advanced count up to the page length when the other requests leave it below.
- R7: When the advanced count reaches or exceeds the page length, the page length is subtracted from it and page_ovf is high for exactly that one cycle, together with feed_valid. feed_lines always equals the total advance before the wrap.
- R8: Request bits accumulate by OR across req_valid cycles (a print counts the bits presented in its own cycle too). An accepted command start clears them. A print does not clear them.
- R9: A command start is accepted only when cmd_dev is 1 or 2. Code 2 sets cmd_binary. Codes 0 and 3 give no accept pulse and leave the requests intact.
- R10: An accepted start reports a delay of 85 when mech_ready is high and 330 when it is low.
- R11: After reset the line count is 0, the page length is 55, and every pulse output is low.
- R12: The outputs of a print (feed_valid, feed_lines, page_ovf, line_count) appear on the clock edge that samples print_stb. A page-length write in the same cycle takes priority, and that print is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Page-length write strobe |
| cfg_lines | input | 7 | Requested page length |
| cmd_start | input | 1 | Print command start |
| cmd_dev | input | 2 | Device code of the command |
| mech_ready | input | 1 | Mechanism already running and idle |
| req_valid | input | 1 | Carriage request field valid |
| req_bits | input | 5 | Requests: 0 single before, 1 double before, 2 suppress, 3 after, 4 skip to top |
| print_stb | input | 1 | Print the current line |
| cmd_accept | output | 1 | One-cycle pulse for an accepted command |
| cmd_binary | output | 1 | Accepted command is in binary mode |
| cmd_delay | output | 9 | Start-up delay for the accepted command |
| feed_valid | output | 1 | One-cycle pulse carrying a line-feed count |
| feed_lines | output | 7 | Lines advanced by the print |
| page_ovf | output | 1 | One-cycle page-overflow pulse |
| line_count | output | 7 | Lines used on the current page |

## Verification
Some properties are checked on every clock by the assertions:
- the line count stays below the page length;
- a valid write clears the count;
- each new count equals the old count plus the reported advance, minus one page on overflow;
- held requests lose bits only at an accepted start;
- binary mode and the delay values appear only on accepted commands.

Other behaviour only shows up in the bench scenarios, because the assertions see just the totals and not how they are built up:
- the exact per-request line contributions;
- how skip-to-top interacts with spaces before and after;
- that rejected lengths leave later wrap points unchanged;
- that invalid device codes preserve the held requests.

// File: rtl/carriage_pkg.sv
package carriage_pkg;
  typedef struct packed {
    logic skip_top;
    logic space_after;
    logic suppress;
    logic dbl_before;
    logic sgl_before;
  } cc_req_t;

  localparam int REQ_W = 5;
endpackage

// File: rtl/carriage_cmd_decode.sv
module carriage_cmd_decode #(
  parameter int WARM_DELAY = 85,
  parameter int COLD_DELAY = 330,
  localparam int DLY_W = $clog2(COLD_DELAY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic [1:0]       cmd_dev,
  input  logic             mech_ready,
  output logic             start_ok,
  output logic             cmd_accept,
  output logic             cmd_binary,
  output logic [DLY_W-1:0] cmd_delay
);
  assign start_ok = cmd_start && (cmd_dev == 2'd1 || cmd_dev == 2'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_accept <= 1'b0;
      cmd_binary <= 1'b0;
      cmd_delay  <= '0;
    end else begin
      cmd_accept <= start_ok;
      cmd_binary <= start_ok && cmd_dev == 2'd2;
      if (start_ok)
        cmd_delay <= mech_ready ? DLY_W'(WARM_DELAY) : DLY_W'(COLD_DELAY);
      else
        cmd_delay <= '0;
    end
  end

  assert_binary_needs_accept_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_binary |-> cmd_accept);
  assert_accept_from_start_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_accept |-> $past(cmd_start));
  assert_delay_choice_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_accept |-> (cmd_delay == DLY_W'(WARM_DELAY) || cmd_delay == DLY_W'(COLD_DELAY)));
endmodule

// File: rtl/carriage_req_latch.sv
module carriage_req_latch
  import carriage_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    clear,
  input  logic    req_valid,
  input  cc_req_t req_in,
  output cc_req_t req_eff
);
  cc_req_t held;
  cc_req_t incoming;

  assign incoming = req_valid ? req_in : '0;
  assign req_eff  = held | incoming;

  always_ff @(posedge clk) begin
    if (rst)        held <= '0;
    else if (clear) held <= '0;
    else            held <= held | incoming;
  end

  assert_requests_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !clear |=> ((held & $past(held)) == $past(held)));
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
    clear |=> held == '0);
endmodule

// File: rtl/carriage_page_counter.sv
module carriage_page_counter
  import carriage_pkg::*;
#(
  parameter int LPP_MIN   = 20,
  parameter int LPP_MAX   = 100,
  parameter int LPP_RESET = 55,
  localparam int CFG_W    = $clog2(LPP_MAX + 1),
  localparam int CNT_W    = $clog2(LPP_MAX + 6)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_len,
  input  logic             print_stb,
  input  cc_req_t          req,
  output logic [CNT_W-1:0] line_count,
  output logic             feed_valid,
  output logic [CNT_W-1:0] feed_count,
  output logic             page_ovf
);
  logic [CNT_W-1:0] page_len;
  logic [CNT_W:0]   adv;
  logic [CNT_W:0]   len_x;
  logic [CNT_W:0]   nxt;
  logic [CNT_W:0]   feed;
  logic             wrap;
  logic             cfg_ok;

  assign cfg_ok = cfg_we && cfg_len >= CFG_W'(LPP_MIN) && cfg_len <= CFG_W'(LPP_MAX);
  assign len_x  = {1'b0, page_len};

  always_comb begin
    adv = {1'b0, line_count}
        + (CNT_W+1)'(req.sgl_before)
        + (CNT_W+1)'({req.dbl_before, 1'b0})
        + (CNT_W+1)'(!req.suppress)
        + (CNT_W+1)'(req.space_after);
    if (req.skip_top && adv < len_x)
      adv = len_x;
    wrap = adv >= len_x;
    nxt  = wrap ? adv - len_x : adv;
    feed = adv - {1'b0, line_count};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_len   <= CNT_W'(LPP_RESET);
      line_count <= '0;
      feed_valid <= 1'b0;
      feed_count <= '0;
      page_ovf   <= 1'b0;
    end else begin
      feed_valid <= 1'b0;
      page_ovf   <= 1'b0;
      if (cfg_ok) begin
        page_len   <= CNT_W'(cfg_len);
        line_count <= '0;
      end else if (!cfg_we && print_stb) begin
        line_count <= nxt[CNT_W-1:0];
        feed_valid <= 1'b1;
        feed_count <= feed[CNT_W-1:0];
        page_ovf   <= wrap;
      end
    end
  end

  assert_count_below_page_R7: assert property (@(posedge clk) disable iff (rst)
    line_count < page_len);
  assert_ovf_with_feed_R7: assert property (@(posedge clk) disable iff (rst)
    page_ovf |-> feed_valid);
  assert_count_tracks_feed_R7: assert property (@(posedge clk) disable iff (rst)
    feed_valid |-> ({1'b0, line_count} == {1'b0, $past(line_count)} + {1'b0, feed_count}
                    - (page_ovf ? {1'b0, page_len} : '0)));
  assert_cfg_clears_R1: assert property (@(posedge clk) disable iff (rst)
    cfg_ok |=> line_count == '0);
  assert_len_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    page_len >= CNT_W'(LPP_MIN) && page_len <= CNT_W'(LPP_MAX));
endmodule

// File: rtl/carriage_page_ctrl.sv
module carriage_page_ctrl
  import carriage_pkg::*;
#(
  parameter int LPP_MIN    = 20,
  parameter int LPP_MAX    = 100,
  parameter int LPP_RESET  = 55,
  parameter int WARM_DELAY = 85,
  parameter int COLD_DELAY = 330,
  localparam int CFG_W     = $clog2(LPP_MAX + 1),
  localparam int CNT_W     = $clog2(LPP_MAX + 6),
  localparam int DLY_W     = $clog2(COLD_DELAY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_lines,
  input  logic             cmd_start,
  input  logic [1:0]       cmd_dev,
  input  logic             mech_ready,
  input  logic             req_valid,
  input  logic [REQ_W-1:0] req_bits,
  input  logic             print_stb,
  output logic             cmd_accept,
  output logic             cmd_binary,
  output logic [DLY_W-1:0] cmd_delay,
  output logic             feed_valid,
  output logic [CNT_W-1:0] feed_lines,
  output logic             page_ovf,
  output logic [CNT_W-1:0] line_count
);
  logic    start_ok;
  cc_req_t req_eff;

  carriage_cmd_decode #(
    .WARM_DELAY (WARM_DELAY),
    .COLD_DELAY (COLD_DELAY)
  ) i_cmd (
    .clk        (clk),
    .rst        (rst),
    .cmd_start  (cmd_start),
    .cmd_dev    (cmd_dev),
    .mech_ready (mech_ready),
    .start_ok   (start_ok),
    .cmd_accept (cmd_accept),
    .cmd_binary (cmd_binary),
    .cmd_delay  (cmd_delay)
  );

  carriage_req_latch i_req (
    .clk       (clk),
    .rst       (rst),
    .clear     (start_ok),
    .req_valid (req_valid),
    .req_in    (cc_req_t'(req_bits)),
    .req_eff   (req_eff)
  );

  carriage_page_counter #(
    .LPP_MIN   (LPP_MIN),
    .LPP_MAX   (LPP_MAX),
    .LPP_RESET (LPP_RESET)
  ) i_cnt (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_len    (cfg_lines),
    .print_stb  (print_stb),
    .req        (req_eff),
    .line_count (line_count),
    .feed_valid (feed_valid),
    .feed_count (feed_lines),
    .page_ovf   (page_ovf)
  );

  assert_outputs_quiet_after_reset_R11: assert property (@(posedge clk)
    $past(rst) |-> (!feed_valid && !page_ovf && !cmd_accept && line_count == '0));
  assert_print_feed_same_edge_R12: assert property (@(posedge clk) disable iff (rst)
    feed_valid |-> $past(print_stb) && !$past(cfg_we));
endmodule

// File: tb/test_carriage_page_ctrl.sv
module test_carriage_page_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_we, cmd_start, mech_ready, req_valid, print_stb;
  logic [6:0] cfg_lines;
  logic [1:0] cmd_dev;
  logic [4:0] req_bits;
  logic       cmd_accept, cmd_binary, feed_valid, page_ovf;
  logic [8:0] cmd_delay;
  logic [6:0] feed_lines, line_count;

  int n_chk = 0, n_bad = 0;
  int m_len, m_cnt;
  logic [4:0] m_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  carriage_page_ctrl i_carriage_page_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_lines(cfg_lines),
    .cmd_start(cmd_start), .cmd_dev(cmd_dev), .mech_ready(mech_ready),
    .req_valid(req_valid), .req_bits(req_bits), .print_stb(print_stb),
    .cmd_accept(cmd_accept), .cmd_binary(cmd_binary), .cmd_delay(cmd_delay),
    .feed_valid(feed_valid), .feed_lines(feed_lines), .page_ovf(page_ovf),
    .line_count(line_count));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cfg_we = 0; cmd_start = 0; req_valid = 0; print_stb = 0;
    cfg_lines = '0; cmd_dev = '0; req_bits = '0; mech_ready = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // R1 R2: page-length write
  task automatic do_cfg(input int v);
    @(negedge clk);
    cfg_we = 1; cfg_lines = 7'(v);
    step();
    idle_inputs();
    if (v >= 20 && v <= 100) begin m_len = v; m_cnt = 0; end
    check(v >= 20 && v <= 100 ? "R1 count cleared" : "R2 count kept", line_count, m_cnt);
    check("R12 no feed on write", feed_valid, 0);
  endtask

  // R9 R10 R8: command start
  task automatic do_cmd(input int dev, input bit rdy);
    bit ok;
    ok = (dev == 1 || dev == 2);
    @(negedge clk);
    cmd_start = 1; cmd_dev = 2'(dev); mech_ready = rdy;
    step();
    idle_inputs();
    if (ok) m_req = '0;
    check("R9 accept", cmd_accept, ok);
    check("R9 binary", cmd_binary, ok && dev == 2);
    check("R10 delay", cmd_delay, ok ? (rdy ? 85 : 330) : 0);
  endtask

  task automatic do_req(input logic [4:0] b);
    @(negedge clk);
    req_valid = 1; req_bits = b;
    step();
    idle_inputs();
    m_req |= b;
  endtask

  // R3..R7, R12: expected advance from the requirements
  function automatic int exp_adv(input int cnt, input int len, input logic [4:0] r);
    int a;
    a = cnt + (r[0] ? 1 : 0) + (r[1] ? 2 : 0) + (r[2] ? 0 : 1) + (r[3] ? 1 : 0);
    if (r[4] && a < len) a = len;
    return a;
  endfunction

  task automatic do_print(input bit with_req, input logic [4:0] b, input string tag);
    int a, ec;
    bit ov;
    @(negedge clk);
    print_stb = 1;
    if (with_req) begin req_valid = 1; req_bits = b; m_req |= b; end
    a  = exp_adv(m_cnt, m_len, m_req);
    ov = a >= m_len;
    ec = ov ? a - m_len : a;
    step();
    idle_inputs();
    check({tag, " feed_valid"}, feed_valid, 1);
    check({tag, " feed_lines"}, feed_lines, a - m_cnt);
    check("R7 page_ovf", page_ovf, ov);
    check({tag, " line_count"}, line_count, ec);
    m_cnt = ec;
    step();
    check("R7 pulse one cycle", page_ovf, 0);
    check("R12 feed pulse one cycle", feed_valid, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 1234;
    void'($urandom(seed));
    idle_inputs();
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    m_len = 55; m_cnt = 0; m_req = '0;
    check("R11 line_count", line_count, 0);
    check("R11 feed_valid", feed_valid, 0);
    check("R11 page_ovf", page_ovf, 0);
    check("R11 cmd_accept", cmd_accept, 0);

    // R3 default and suppress
    do_print(0, '0, "R3 default");
    do_print(1, 5'b00100, "R3 suppress");
    do_cmd(1, 0);
    // R4 single and double
    do_print(1, 5'b00001, "R4 single");
    do_cmd(2, 1);
    do_print(1, 5'b00010, "R4 double");
    do_cmd(1, 1);
    // R5
    do_print(1, 5'b01000, "R5 after");
    do_cmd(1, 1);
    // R6 skip from mid page
    do_print(1, 5'b10000, "R6 skip");
    // R8 accumulation then invalid codes keep it
    do_req(5'b00001);
    do_cmd(0, 1);
    do_req(5'b01000);
    do_cmd(3, 0);
    do_print(0, '0, "R8 accumulated");
    do_print(0, '0, "R8 kept after print");
    do_cmd(2, 0);
    do_print(0, '0, "R8 cleared");
    // R2 rejections, R1 limits
    do_cfg(19);
    do_cfg(101);
    do_cfg(0);
    do_cfg(127);
    do_print(0, '0, "R2 length kept");
    do_cfg(20);
    do_cfg(100);
    do_cfg(20);
    // R7 wrap with everything near the end
    repeat (17) do_print(0, '0, "R7 fill");
    do_print(1, 5'b01011, "R7 wrap");
    do_cmd(1, 0);
    do_print(1, 5'b11011, "R6 skip with spaces");
    // R12: write with print in same cycle drops print
    @(negedge clk);
    cfg_we = 1; cfg_lines = 7'd30; print_stb = 1;
    step();
    idle_inputs();
    m_len = 30; m_cnt = 0;
    check("R12 write wins feed", feed_valid, 0);
    check("R12 write wins count", line_count, 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op == 0)      do_cfg(int'($urandom_range(10, 110)));
      else if (op == 1) do_cmd(int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      else if (op == 2) do_req(5'($urandom_range(0, 31)));
      else if (op < 6)  do_print(1, 5'($urandom_range(0, 31)) & 5'b01111, "R3 R4 R5 random");
      else              do_print(1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)), "R6 R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule